// File: doc/BRIEF.md
# Synthesizer Register Bank with Fast-Lock Sequencer

This block is the digital control front end of a fractional-N frequency synthesizer. Configuration arrives as 24-bit words over a three-wire serial link (serial clock, serial data, load strobe). The three lowest bits of each word pick the target register. A frequency word carries the integer and fractional divide values. Two auxiliary words carry the reload values of four timeout counters. An auxiliary write only fills a staging copy. That copy is committed along with the next frequency word.

The whole block runs on one system clock. Edges of the serial clock and the load strobe are detected in that domain, and each phase-detector cycle arrives as a one-cycle `pfdTick` strobe. A committed frequency word reaches the divider outputs on the first phase-detector tick after the load. That same tick starts a fast-lock sequence: a charge-pump boost flag and three loop-filter switch closures. Each of the four is released by its own down-counter, which counts phase-detector ticks.

Top module: `synth_ctl_top`

## Requirements
- R1: Serial data is shifted in MSB first on each rising edge of `sclk`, and the last 24 bits are decoded on the rising edge of `sle`. Select code 000 (bits 2:0) is the frequency word: bits 22:15 hold the integer value and bits 14:3 hold the fractional value.
- R2: Select code 001 stages the boost reload (bits 12:3) and the switch-1 reload (bits 22:13). Select code 010 stages the switch-2 reload (bits 12:3) and the switch-3 reload (bits 22:13).
- R3: Words with select codes 011 to 111 change no staged, pending or active state.
- R4: `intOut` and `fracOut` take the frequency word's values on the first `pfdTick` strictly after the cycle in which the load edge is seen. A tick in that same cycle does not apply the word.
- R5: A frequency load takes a snapshot of the staged reload values. Auxiliary writes made after that load, but before the tick that applies it, wait for the next frequency load.
- R6: On the applying tick, each output with a nonzero reload N (`cpBoost`, `swClose[0..2]`) goes high. It goes low after exactly N further ticks. An output whose reload is 0 stays low.
- R7: A frequency word applied while fast lock is running reloads all four counters from the new snapshot.
- R8: An integer value below 26 is applied as 26, and `intInvalid` goes high on that tick. The next applied word with a legal integer value clears it.
- R9: A synchronous reset sets `intOut` to 26, `fracOut` to 0, all fast-lock outputs and `intInvalid` low. It also clears every staged reload and any pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| sle | input | 1 | Load strobe, word decoded on its rising edge |
| pfdTick | input | 1 | One-cycle strobe per phase-detector cycle |
| intOut | output | 8 | Active integer divide value |
| fracOut | output | 12 | Active fractional numerator |
| cpBoost | output | 1 | Charge-pump maximum-current request |
| swClose | output | 3 | Loop-filter switch closures, bit 0 is switch 1 |
| intInvalid | output | 1 | Last applied integer value was clamped |

## Verification
Two things can land in the same cycle and compete. One is a frequency load strobe against a phase-detector tick. The other is a counter reload against a counter decrement. The bench raises `pfdTick` in the very cycle the load edge is decoded. It then expects the old divider values to remain until the following tick. It also applies a new frequency word partway through a countdown. It judges the reload by whether the boost survives past the point where the old count would have expired, and whether an already released switch closes again.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int SEL_W      = 3;
  localparam int INT_W      = 8;
  localparam int FRAC_W     = 12;
  localparam int TIME_W     = 10;
  localparam int NUM_TIMERS = 4;
  localparam int WORD_W     = 1 + INT_W + FRAC_W + SEL_W;

  localparam logic [SEL_W-1:0] SEL_FREQ = 3'd0;
  localparam logic [SEL_W-1:0] SEL_AUXA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_AUXB = 3'd2;

  typedef struct packed {
    logic stageFreq;
    logic stageAuxA;
    logic stageAuxB;
    logic apply;
    logic tick;
  } ctlStrobes_t;
endpackage

// File: rtl/synth_ctl_serial.sv
module synth_ctl_serial
  import synth_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sle,
  input  logic              pfdTick,
  output logic [WORD_W-1:0] wordOut,
  output ctlStrobes_t       strobes
);
  logic              sclkQ;
  logic              sleQ;
  logic              pending;
  logic              sclkRise;
  logic              sleRise;
  logic [WORD_W-1:0] shiftReg;
  logic [SEL_W-1:0]  sel;

  assign sclkRise = sclk & ~sclkQ;
  assign sleRise  = sle & ~sleQ;
  assign sel      = shiftReg[SEL_W-1:0];
  assign wordOut  = shiftReg;

  always_comb begin
    strobes.stageFreq = sleRise && (sel == SEL_FREQ);
    strobes.stageAuxA = sleRise && (sel == SEL_AUXA);
    strobes.stageAuxB = sleRise && (sel == SEL_AUXB);
    strobes.apply     = pending && pfdTick;
    strobes.tick      = pfdTick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ    <= 1'b0;
      sleQ     <= 1'b0;
      pending  <= 1'b0;
      shiftReg <= '0;
    end else begin
      sclkQ <= sclk;
      sleQ  <= sle;
      if (sclkRise) shiftReg <= {shiftReg[WORD_W-2:0], sdata};
      if (strobes.stageFreq) pending <= 1'b1;
      else if (strobes.apply) pending <= 1'b0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.stageFreq, strobes.stageAuxA, strobes.stageAuxB})); // R3

  AST_APPLY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.stageFreq |=> (strobes.apply == pfdTick)); // R4
endmodule

// File: rtl/synth_ctl_core.sv
module synth_ctl_core
  import synth_ctl_pkg::*;
#(
  parameter int MIN_INT = 26
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     wordIn,
  input  ctlStrobes_t           strobes,
  output logic [INT_W-1:0]      intOut,
  output logic [FRAC_W-1:0]     fracOut,
  output logic                  cpBoost,
  output logic [NUM_TIMERS-2:0] swClose,
  output logic                  intInvalid
);
  localparam logic [INT_W-1:0] INT_FLOOR = INT_W'(MIN_INT);

  logic [INT_W-1:0]  wInt;
  logic [FRAC_W-1:0] wFrac;
  logic [TIME_W-1:0] wLo;
  logic [TIME_W-1:0] wHi;

  logic [NUM_TIMERS-1:0][TIME_W-1:0] stageTime;
  logic [NUM_TIMERS-1:0][TIME_W-1:0] pendTime;
  logic [NUM_TIMERS-1:0][TIME_W-1:0] cnt;
  logic [NUM_TIMERS-1:0]             timerOn;
  logic [INT_W-1:0]                  pendInt;
  logic [FRAC_W-1:0]                 pendFrac;
  logic                              pendBad;

  assign wInt  = wordIn[SEL_W+FRAC_W +: INT_W];
  assign wFrac = wordIn[SEL_W +: FRAC_W];
  assign wLo   = wordIn[SEL_W +: TIME_W];
  assign wHi   = wordIn[SEL_W+TIME_W +: TIME_W];

  // staging and snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      stageTime <= '0;
      pendTime  <= '0;
      pendInt   <= INT_FLOOR;
      pendFrac  <= '0;
      pendBad   <= 1'b0;
    end else begin
      if (strobes.stageAuxA) begin
        stageTime[0] <= wLo;
        stageTime[1] <= wHi;
      end
      if (strobes.stageAuxB) begin
        stageTime[2] <= wLo;
        stageTime[3] <= wHi;
      end
      if (strobes.stageFreq) begin
        pendTime <= stageTime;
        pendInt  <= (wInt < INT_FLOOR) ? INT_FLOOR : wInt;
        pendBad  <= (wInt < INT_FLOOR);
        pendFrac <= wFrac;
      end
    end
  end

  // active divider values
  always_ff @(posedge clk) begin
    if (rst) begin
      intOut     <= INT_FLOOR;
      fracOut    <= '0;
      intInvalid <= 1'b0;
    end else if (strobes.apply) begin
      intOut     <= pendInt;
      fracOut    <= pendFrac;
      intInvalid <= pendBad;
    end
  end

  // timeout counters: 0 = boost, 1..3 = switches
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    always_ff @(posedge clk) begin
      if (rst) cnt[t] <= '0;
      else if (strobes.apply) cnt[t] <= pendTime[t];
      else if (strobes.tick && cnt[t] != '0) cnt[t] <= cnt[t] - 1'b1;
    end
    assign timerOn[t] = (cnt[t] != '0);

    AST_TIMER_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(timerOn[t]) |-> $past(strobes.apply)); // R6
  end

  assign cpBoost = timerOn[0];
  assign swClose = timerOn[NUM_TIMERS-1:1];

  AST_INT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    intOut >= INT_FLOOR); // R8

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.apply |=> $stable(intOut) && $stable(fracOut)); // R4

  AST_BOOST_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(cpBoost) |-> $past(strobes.tick) || $past(rst)); // R6

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (strobes.apply && pendTime[0] != '0) |=> cpBoost); // R7
endmodule

// File: rtl/synth_ctl_top.sv
module synth_ctl_top
  import synth_ctl_pkg::*;
#(
  parameter int MIN_INT = 26
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  sdata,
  input  logic                  sle,
  input  logic                  pfdTick,
  output logic [INT_W-1:0]      intOut,
  output logic [FRAC_W-1:0]     fracOut,
  output logic                  cpBoost,
  output logic [NUM_TIMERS-2:0] swClose,
  output logic                  intInvalid
);
  logic [WORD_W-1:0] word;
  ctlStrobes_t       strobes;

  synth_ctl_serial i_serial (
    .clk     (clk),
    .rst     (rst),
    .sclk    (sclk),
    .sdata   (sdata),
    .sle     (sle),
    .pfdTick (pfdTick),
    .wordOut (word),
    .strobes (strobes)
  );

  synth_ctl_core #(.MIN_INT(MIN_INT)) i_core (
    .clk        (clk),
    .rst        (rst),
    .wordIn     (word),
    .strobes    (strobes),
    .intOut     (intOut),
    .fracOut    (fracOut),
    .cpBoost    (cpBoost),
    .swClose    (swClose),
    .intInvalid (intInvalid)
  );
endmodule

// File: tb/test_synth_ctl_top.sv
`timescale 1ns/1ps
module test_synth_ctl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic sle = 1'b0;
  logic pfdTick = 1'b0;
  logic [7:0]  intOut;
  logic [11:0] fracOut;
  logic        cpBoost;
  logic [2:0]  swClose;
  logic        intInvalid;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  synth_ctl_top i_synth_ctl_top (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sle(sle),
    .pfdTick(pfdTick), .intOut(intOut), .fracOut(fracOut),
    .cpBoost(cpBoost), .swClose(swClose), .intInvalid(intInvalid)
  );

  typedef struct packed {
    logic [7:0]  iv;
    logic [11:0] fv;
    logic [9:0]  b;
    logic [9:0]  s1;
    logic [9:0]  s2;
    logic [9:0]  s3;
    logic [7:0]  expInt;
    logic        expBad;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd100, 12'd1234, 10'd3, 10'd5, 10'd2, 10'd4, 8'd100, 1'b0},
    '{8'd26,  12'd0,    10'd1, 10'd1, 10'd1, 10'd1, 8'd26,  1'b0},
    '{8'd255, 12'd4095, 10'd0, 10'd6, 10'd3, 10'd2, 8'd255, 1'b0},
    '{8'd10,  12'd77,   10'd2, 10'd2, 10'd2, 10'd2, 8'd26,  1'b1},
    '{8'd200, 12'd2048, 10'd4, 10'd3, 10'd6, 10'd1, 8'd200, 1'b0}
  };

  function automatic logic [23:0] freqWord(input logic [7:0] iv, input logic [11:0] fv);
    return {1'b0, iv, fv, 3'b000};
  endfunction
  function automatic logic [23:0] auxWord(input logic [2:0] sel, input logic [9:0] lo, input logic [9:0] hi);
    return {1'b0, hi, lo, sel};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [23:0] w, input bit tickOnLoad);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); sdata = w[i]; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk); sle = 1'b1; pfdTick = tickOnLoad;
    @(negedge clk); sle = 1'b0; pfdTick = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); pfdTick = 1'b1;
    @(negedge clk); pfdTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulseTick();
  endtask

  function automatic logic [3:0] timers();
    return {swClose, cpBoost};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(intOut == 8'd26, "R9 reset int", intOut, 26);
    check(fracOut == 12'd0, "R9 reset frac", fracOut, 0);
    check(timers() == 4'd0 && !intInvalid, "R9 reset outputs", {intInvalid, timers()}, 0);

    // table: R1 R2 R6 R8
    for (int v = 0; v < NV; v++) begin
      sendWord(auxWord(3'b001, VECS[v].b, VECS[v].s1), 1'b0);
      sendWord(auxWord(3'b010, VECS[v].s2, VECS[v].s3), 1'b0);
      sendWord(freqWord(VECS[v].iv, VECS[v].fv), 1'b0);
      pulseTick();
      check(intOut == VECS[v].expInt, "R1/R8 int", intOut, VECS[v].expInt);
      check(fracOut == VECS[v].fv, "R1 frac", fracOut, VECS[v].fv);
      check(intInvalid == VECS[v].expBad, "R8 invalid flag", intInvalid, VECS[v].expBad);
      for (int k = 0; k < 8; k++) begin
        logic [3:0] e;
        e = {VECS[v].s3 > k, VECS[v].s2 > k, VECS[v].s1 > k, VECS[v].b > k};
        check(timers() == e, "R2/R6 timer outputs", timers(), e);
        pulseTick();
      end
    end

    // R4 deferral: int 200 active
    sendWord(freqWord(8'd150, 12'd5), 1'b0);
    check(intOut == 8'd200, "R4 before tick", intOut, 200);
    pulseTick();
    check(intOut == 8'd150 && fracOut == 12'd5, "R4 after tick", intOut, 150);
    ticks(8);

    // R4 coincident load and tick
    sendWord(freqWord(8'd90, 12'd9), 1'b1);
    check(intOut == 8'd150, "R4 coincident tick ignored", intOut, 150);
    pulseTick();
    check(intOut == 8'd90, "R4 applied on next tick", intOut, 90);
    ticks(8);

    // R5 snapshot at load
    sendWord(auxWord(3'b001, 10'd2, 10'd1), 1'b0);
    sendWord(auxWord(3'b010, 10'd1, 10'd1), 1'b0);
    sendWord(freqWord(8'd60, 12'd60), 1'b0);
    sendWord(auxWord(3'b001, 10'd8, 10'd1), 1'b0);
    pulseTick();
    ticks(1);
    check(cpBoost == 1'b1, "R5 boost after 1", cpBoost, 1);
    ticks(1);
    check(cpBoost == 1'b0, "R5 old snapshot used", cpBoost, 0);
    ticks(8);
    sendWord(freqWord(8'd60, 12'd60), 1'b0);
    pulseTick();
    ticks(7);
    check(cpBoost == 1'b1, "R5 later write committed", cpBoost, 1);
    ticks(1);
    check(cpBoost == 1'b0, "R5 boost expires at 8", cpBoost, 0);

    // R3 ignored select codes
    sendWord({1'b0, 8'd33, 12'hABC, 3'b011}, 1'b0);
    sendWord({1'b0, 8'd34, 12'h123, 3'b111}, 1'b0);
    pulseTick();
    check(intOut == 8'd60 && fracOut == 12'd60, "R3 divider unchanged", intOut, 60);
    check(timers() == 4'd0, "R3 no fast lock", timers(), 0);
    sendWord(freqWord(8'd61, 12'd1), 1'b0);
    pulseTick();
    ticks(7);
    check(cpBoost == 1'b1, "R3 staged reload intact", cpBoost, 1);
    ticks(1);
    check(cpBoost == 1'b0, "R3 staged reload intact end", cpBoost, 0);

    // R7 restart during fast lock (boost 8, switches 1)
    sendWord(freqWord(8'd70, 12'd2), 1'b0);
    pulseTick();
    ticks(3);
    check(swClose == 3'b000 && cpBoost, "R7 mid countdown", timers(), 1);
    sendWord(freqWord(8'd71, 12'd3), 1'b0);
    pulseTick();
    check(timers() == 4'b1111, "R7 switches reclosed", timers(), 15);
    ticks(6);
    check(cpBoost == 1'b1, "R7 boost reloaded", cpBoost, 1);
    ticks(2);
    check(cpBoost == 1'b0, "R7 boost ends after reload", cpBoost, 0);

    // R9 reset during fast lock, pending cleared
    sendWord(freqWord(8'd80, 12'd4), 1'b0);
    pulseTick();
    sendWord(freqWord(8'd81, 12'd5), 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(timers() == 4'd0 && intOut == 8'd26, "R9 reset mid lock", {intOut, timers()}, 26 << 4);
    pulseTick();
    check(intOut == 8'd26 && timers() == 4'd0, "R9 pending cleared", intOut, 26);
    sendWord(freqWord(8'd90, 12'd0), 1'b0);
    pulseTick();
    check(timers() == 4'd0, "R9 staged reloads cleared", timers(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule